// File: doc/BRIEF.md
# Dual-Channel Pulse Counting Unit

This block counts edges on two pulse inputs with one signed up/down counter. Each channel has a pulse line and a level line. Both lines pass through a two-flop synchronizer. The pulse line then goes through an optional glitch filter, which only accepts a new level after it has been held for a set number of clock cycles.

Rising and falling edges of each filtered pulse produce a step of +1, -1 or nothing. The step is chosen by a per-edge mode field and then adjusted by a per-level control mode. The control mode can keep the step, reverse it, or block it, depending on whether the channel's level line is high or low. If both channels step in the same cycle, the two steps are added and applied as one update.

After every update that moves the count, the new value is compared against five targets: zero, a high limit, a low limit and two free thresholds. Each target has its own enable. An enabled hit does four things:
- it flags an event;
- it records which targets fired;
- it records a two-bit zone code describing the crossing;
- it sets an interrupt raw bit.

The interrupt raw bit is masked by an enable and cleared by a clear strobe. A limit hit returns the count to zero. Software-style clear and hold inputs reset or freeze the counter.

Top module: `pulse_tally_unit`

## Requirements
- R1: After reset the count, hit record, zone code, event output and interrupt raw bit are all zero.
- R2: Edge modes are 2 bits per channel and edge direction. Code 1 counts up one on that edge, code 2 counts down one, and codes 0 and 3 leave the count unchanged.
- R3: The level line of a channel selects the high-level control mode (level 1) or the low-level control mode (level 0). Control code 0 keeps the edge step, code 1 reverses it, and codes 2 and 3 block it.
- R4: When both channels produce a step in the same cycle, the count moves by their sum (-2 to +2) in one update.
- R5: With the filter enabled and threshold T, a pulse level held for fewer than T cycles is discarded and produces no edge. A level held for T or more cycles is accepted. With the filter disabled, every synchronized change is accepted.
- R6: The clear input forces the count to zero and has priority over hold. While hold is set and clear is not, the count does not change.
- R7: Targets are checked only in cycles where the count moves, and only enabled targets can hit. Zero, threshold 0 and threshold 1 hit on equality. The high limit hits when the new value is greater than or equal to it, and the low limit hits when the new value is less than or equal to it (signed).
- R8: A high- or low-limit hit loads zero into the count in the same update.
- R9: On an event the hit record is loaded with the set of targets that fired: bit 0 zero, bit 1 high limit, bit 2 low limit, bit 3 threshold 0, bit 4 threshold 1. It keeps its value until the next event.
- R10: On an event the zone code is loaded from the new count. If the new count is zero, the code is 0 when the previous count was not negative and 1 when it was negative. Otherwise the code is 2 for a negative count and 3 for a positive count.
- R11: An event sets the interrupt raw bit. The clear strobe clears it, and a simultaneous event wins over the clear. The status output is raw AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_in | input | 2 | Pulse line per channel (bit i = channel i) |
| level_in | input | 2 | Control level line per channel |
| filt_en | input | 1 | Glitch filter enable |
| filt_thresh | input | 10 | Minimum accepted pulse width in clock cycles |
| rise_mode | input | 4 | Rising-edge mode, bits [2i+1:2i] for channel i |
| fall_mode | input | 4 | Falling-edge mode, bits [2i+1:2i] for channel i |
| hi_mode | input | 4 | Control mode while level is high, per channel |
| lo_mode | input | 4 | Control mode while level is low, per channel |
| cmp_en | input | 5 | Target enables: zero, high limit, low limit, threshold 0, threshold 1 |
| thresh0 | input | 16 | Signed threshold 0 |
| thresh1 | input | 16 | Signed threshold 1 |
| hi_lim | input | 16 | Signed high limit |
| lo_lim | input | 16 | Signed low limit |
| clr_cnt | input | 1 | Clear the count |
| hold_cnt | input | 1 | Freeze the count |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Interrupt clear strobe |
| count | output | 16 | Signed count value |
| hit_kind | output | 5 | Targets that fired at the last event |
| zone_code | output | 2 | Zone code latched at the last event |
| event_pulse | output | 1 | One-cycle flag, high in the cycle after an event update |
| irq_raw | output | 1 | Interrupt raw bit |
| irq_status | output | 1 | Masked interrupt |

## Verification
With the filter disabled, a pulse-line change at the input reaches the count on the fourth rising clock edge: two synchronizer flops, the filter register, then the counter update. With a filter threshold T above 1 it lands on edge 3+T. The hit record, zone code and raw bit are registered on the same edge as the count. The clear and hold inputs act on the next edge, and the status output follows raw and enable without delay. The bench drives on falling edges and waits at least eight cycles, well beyond the longest path used, before sampling on a falling edge, so every expected value has settled.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  typedef logic signed [1:0] step_t;

  localparam step_t STEP_NONE = 2'sb00;
  localparam step_t STEP_UP   = 2'sb01;
  localparam step_t STEP_DN   = 2'sb11;

  localparam logic [1:0] EDGE_UP = 2'd1;
  localparam logic [1:0] EDGE_DN = 2'd2;

  localparam logic [1:0] CTL_KEEP = 2'd0;
  localparam logic [1:0] CTL_FLIP = 2'd1;

  localparam int HIT_ZERO = 0;
  localparam int HIT_HI   = 1;
  localparam int HIT_LO   = 2;
  localparam int HIT_TH0  = 3;
  localparam int HIT_TH1  = 4;
  localparam int NUM_HIT  = 5;

  typedef enum logic [1:0] {
    ZONE_POS_TO_ZERO = 2'd0,
    ZONE_NEG_TO_ZERO = 2'd1,
    ZONE_NEGATIVE    = 2'd2,
    ZONE_POSITIVE    = 2'd3
  } zone_e;

  function automatic step_t edge_step(input logic [1:0] edge_mode,
                                      input logic [1:0] ctl_mode);
    step_t base;
    if (edge_mode == EDGE_UP)      base = STEP_UP;
    else if (edge_mode == EDGE_DN) base = STEP_DN;
    else                           base = STEP_NONE;
    if (ctl_mode == CTL_KEEP)      return base;
    else if (ctl_mode == CTL_FLIP) return (base == STEP_UP) ? STEP_DN :
                                          (base == STEP_DN) ? STEP_UP : STEP_NONE;
    else                           return STEP_NONE;
  endfunction
endpackage

// File: rtl/ptu_input_cond.sv
module ptu_input_cond #(
  parameter int FILT_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_raw,
  input  logic              level_raw,
  input  logic              filt_en,
  input  logic [FILT_W-1:0] filt_thresh,
  output logic              rise,
  output logic              fall,
  output logic              level_q
);
  localparam int RUN_W = FILT_W + 1;

  logic [SYNC_STAGES-1:0] p_sync_q, l_sync_q;
  logic                   p_s;
  logic                   filt_q, filt_d;
  logic                   prev_q;
  logic [FILT_W-1:0]      run_q, run_d;
  logic [RUN_W-1:0]       run_inc;

  assign p_s     = p_sync_q[SYNC_STAGES-1];
  assign run_inc = {1'b0, run_q} + RUN_W'(1);

  // filter next state: adopt a new level once it has persisted long enough
  always_comb begin
    filt_d = filt_q;
    run_d  = '0;
    if (!filt_en) begin
      filt_d = p_s;
    end else if (p_s != filt_q) begin
      if (run_inc >= {1'b0, filt_thresh}) begin
        filt_d = p_s;
      end else begin
        run_d = run_inc[FILT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sync_q <= '0;
      l_sync_q <= '0;
      filt_q   <= 1'b0;
      run_q    <= '0;
      prev_q   <= 1'b0;
      level_q  <= 1'b0;
    end else begin
      p_sync_q <= {p_sync_q[SYNC_STAGES-2:0], pulse_raw};
      l_sync_q <= {l_sync_q[SYNC_STAGES-2:0], level_raw};
      filt_q   <= filt_d;
      run_q    <= run_d;
      prev_q   <= filt_q;
      level_q  <= l_sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = filt_q & ~prev_q;
  assign fall = ~filt_q & prev_q;
endmodule

// File: rtl/ptu_step_decode.sv
module ptu_step_decode
  import ptu_pkg::*;
(
  input  logic       rise,
  input  logic       fall,
  input  logic       level,
  input  logic [1:0] rise_mode,
  input  logic [1:0] fall_mode,
  input  logic [1:0] hi_mode,
  input  logic [1:0] lo_mode,
  output step_t      step
);
  logic [1:0] ctl_sel;

  assign ctl_sel = level ? hi_mode : lo_mode;

  always_comb begin
    if (rise)      step = edge_step(rise_mode, ctl_sel);
    else if (fall) step = edge_step(fall_mode, ctl_sel);
    else           step = STEP_NONE;
  end
endmodule

// File: rtl/ptu_counter_core.sv
module ptu_counter_core
  import ptu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SUM_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SUM_W-1:0] step_sum,
  input  logic                    clr_cnt,
  input  logic                    hold_cnt,
  input  logic [NUM_HIT-1:0]      cmp_en,
  input  logic [CNT_W-1:0]        thresh0,
  input  logic [CNT_W-1:0]        thresh1,
  input  logic [CNT_W-1:0]        hi_lim,
  input  logic [CNT_W-1:0]        lo_lim,
  input  logic                    irq_clr,
  output logic [CNT_W-1:0]        count,
  output logic [NUM_HIT-1:0]      hit_kind,
  output logic [1:0]              zone_code,
  output logic                    event_pulse,
  output logic                    irq_raw
);
  logic signed [CNT_W-1:0] cnt_q, cnt_d, cand, landed;
  logic [NUM_HIT-1:0]      hits, hit_q, hit_d;
  logic [1:0]              zone_q, zone_d;
  logic                    move, evt, wrap;
  logic                    evt_q, raw_q, raw_d;

  assign cand = cnt_q + {{(CNT_W-SUM_W){step_sum[SUM_W-1]}}, step_sum};
  assign move = !clr_cnt && !hold_cnt && (step_sum != '0);

  always_comb begin
    hits           = '0;
    hits[HIT_ZERO] = cmp_en[HIT_ZERO] && (cand == '0);
    hits[HIT_HI]   = cmp_en[HIT_HI]   && (cand >= $signed(hi_lim));
    hits[HIT_LO]   = cmp_en[HIT_LO]   && (cand <= $signed(lo_lim));
    hits[HIT_TH0]  = cmp_en[HIT_TH0]  && (cand == $signed(thresh0));
    hits[HIT_TH1]  = cmp_en[HIT_TH1]  && (cand == $signed(thresh1));
    if (!move) hits = '0;
  end

  assign evt    = |hits;
  assign wrap   = hits[HIT_HI] | hits[HIT_LO];
  assign landed = wrap ? '0 : cand;

  always_comb begin
    if (clr_cnt)   cnt_d = '0;
    else if (move) cnt_d = landed;
    else           cnt_d = cnt_q;
  end

  always_comb begin
    hit_d  = hit_q;
    zone_d = zone_q;
    if (evt) begin
      hit_d = hits;
      if (landed == '0)
        zone_d = (cnt_q < 0) ? ZONE_NEG_TO_ZERO : ZONE_POS_TO_ZERO;
      else
        zone_d = (landed < 0) ? ZONE_NEGATIVE : ZONE_POSITIVE;
    end
  end

  always_comb begin
    raw_d = raw_q;
    if (evt)          raw_d = 1'b1;
    else if (irq_clr) raw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hit_q  <= '0;
      zone_q <= ZONE_POS_TO_ZERO;
      evt_q  <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hit_q  <= hit_d;
      zone_q <= zone_d;
      evt_q  <= evt;
      raw_q  <= raw_d;
    end
  end

  assign count       = cnt_q;
  assign hit_kind    = hit_q;
  assign zone_code   = zone_q;
  assign event_pulse = evt_q;
  assign irq_raw     = raw_q;
endmodule

// File: rtl/pulse_tally_unit.sv
module pulse_tally_unit
  import ptu_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 16,
  parameter int FILT_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   pulse_in,
  input  logic [NUM_CH-1:0]   level_in,
  input  logic                filt_en,
  input  logic [FILT_W-1:0]   filt_thresh,
  input  logic [2*NUM_CH-1:0] rise_mode,
  input  logic [2*NUM_CH-1:0] fall_mode,
  input  logic [2*NUM_CH-1:0] hi_mode,
  input  logic [2*NUM_CH-1:0] lo_mode,
  input  logic [4:0]          cmp_en,
  input  logic [CNT_W-1:0]    thresh0,
  input  logic [CNT_W-1:0]    thresh1,
  input  logic [CNT_W-1:0]    hi_lim,
  input  logic [CNT_W-1:0]    lo_lim,
  input  logic                clr_cnt,
  input  logic                hold_cnt,
  input  logic                irq_en,
  input  logic                irq_clr,
  output logic [CNT_W-1:0]    count,
  output logic [4:0]          hit_kind,
  output logic [1:0]          zone_code,
  output logic                event_pulse,
  output logic                irq_raw,
  output logic                irq_status
);
  localparam int SUM_W = $clog2(NUM_CH) + 2;

  logic [1:0]              rst_sync_q;
  logic                    rst_n_s;
  step_t                   steps [NUM_CH];
  logic signed [SUM_W-1:0] step_sum;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic rise_c, fall_c, level_c;

    ptu_input_cond #(.FILT_W(FILT_W), .SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .pulse_raw  (pulse_in[ch]),
      .level_raw  (level_in[ch]),
      .filt_en    (filt_en),
      .filt_thresh(filt_thresh),
      .rise       (rise_c),
      .fall       (fall_c),
      .level_q    (level_c)
    );

    ptu_step_decode u_dec (
      .rise     (rise_c),
      .fall     (fall_c),
      .level    (level_c),
      .rise_mode(rise_mode[2*ch +: 2]),
      .fall_mode(fall_mode[2*ch +: 2]),
      .hi_mode  (hi_mode[2*ch +: 2]),
      .lo_mode  (lo_mode[2*ch +: 2]),
      .step     (steps[ch])
    );
  end

  always_comb begin
    step_sum = '0;
    for (int i = 0; i < NUM_CH; i++)
      step_sum = step_sum + {{(SUM_W-2){steps[i][1]}}, steps[i]};
  end

  ptu_counter_core #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .step_sum   (step_sum),
    .clr_cnt    (clr_cnt),
    .hold_cnt   (hold_cnt),
    .cmp_en     (cmp_en),
    .thresh0    (thresh0),
    .thresh1    (thresh1),
    .hi_lim     (hi_lim),
    .lo_lim     (lo_lim),
    .irq_clr    (irq_clr),
    .count      (count),
    .hit_kind   (hit_kind),
    .zone_code  (zone_code),
    .event_pulse(event_pulse),
    .irq_raw    (irq_raw)
  );

  assign irq_status = irq_raw & irq_en;
endmodule

// File: rtl/ptu_checker.sv
module ptu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_cnt,
  input logic             hold_cnt,
  input logic             irq_clr,
  input logic [CNT_W-1:0] count,
  input logic [4:0]       hit_kind,
  input logic             event_pulse,
  input logic             irq_raw,
  input logic             irq_status
);
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (count == '0));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt && !clr_cnt) |=> $stable(count));

  // R4: one update moves by at most two, or lands on zero after a limit
  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_cnt && !hold_cnt) |=>
      ((count == '0) || ((count - $past(count) + CNT_W'(2)) <= CNT_W'(4))));

  assert_limit_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (event_pulse && (hit_kind[1] || hit_kind[2])) |-> (count == '0));

  assert_event_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> (hit_kind != 5'd0));

  assert_record_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (event_pulse || $stable(hit_kind)));

  assert_raw_on_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> irq_raw);

  assert_raw_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> (!irq_raw || event_pulse));

  assert_status_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_raw |-> !irq_status);
endmodule

bind pulse_tally_unit ptu_checker #(.CNT_W(CNT_W)) u_ptu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_cnt    (clr_cnt),
  .hold_cnt   (hold_cnt),
  .irq_clr    (irq_clr),
  .count      (count),
  .hit_kind   (hit_kind),
  .event_pulse(event_pulse),
  .irq_raw    (irq_raw),
  .irq_status (irq_status)
);

// File: tb/pulse_tally_unit_bench.sv
`timescale 1ns/1ps
module pulse_tally_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pulse_in, level_in;
  logic        filt_en;
  logic [9:0]  filt_thresh;
  logic [3:0]  rise_mode, fall_mode, hi_mode, lo_mode;
  logic [4:0]  cmp_en;
  logic [15:0] thresh0, thresh1, hi_lim, lo_lim;
  logic        clr_cnt, hold_cnt, irq_en, irq_clr;
  logic [15:0] count;
  logic [4:0]  hit_kind;
  logic [1:0]  zone_code;
  logic        event_pulse, irq_raw, irq_status;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pulse_tally_unit u_pulse_tally_unit (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .level_in(level_in),
    .filt_en(filt_en), .filt_thresh(filt_thresh), .rise_mode(rise_mode),
    .fall_mode(fall_mode), .hi_mode(hi_mode), .lo_mode(lo_mode),
    .cmp_en(cmp_en), .thresh0(thresh0), .thresh1(thresh1), .hi_lim(hi_lim),
    .lo_lim(lo_lim), .clr_cnt(clr_cnt), .hold_cnt(hold_cnt), .irq_en(irq_en),
    .irq_clr(irq_clr), .count(count), .hit_kind(hit_kind),
    .zone_code(zone_code), .event_pulse(event_pulse), .irq_raw(irq_raw),
    .irq_status(irq_status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_step(input int m, input int c);
    int b;
    b = (m == 1) ? 1 : (m == 2) ? -1 : 0;
    if (c == 0) return b;
    if (c == 1) return -b;
    return 0;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clr();
    clr_cnt = 1'b1;
    wait_n(1);
    clr_cnt = 1'b0;
    wait_n(1);
  endtask

  task automatic do_irq_clr();
    irq_clr = 1'b1;
    wait_n(1);
    irq_clr = 1'b0;
    wait_n(1);
  endtask

  // one full pulse on channel 0 (rising edge counts, falling edge mode 0)
  task automatic bump0();
    pulse_in[0] = 1'b1;
    wait_n(8);
    pulse_in[0] = 1'b0;
    wait_n(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pulse_in = '0; level_in = '0; filt_en = 1'b0; filt_thresh = '0;
    rise_mode = '0; fall_mode = '0; hi_mode = '0; lo_mode = '0; cmp_en = '0;
    thresh0 = '0; thresh1 = '0; hi_lim = 16'h7fff; lo_lim = 16'h8000;
    clr_cnt = 1'b0; hold_cnt = 1'b0; irq_en = 1'b0; irq_clr = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    chk("R1 count", int'($signed(count)), 0);
    chk("R1 hit_kind", int'(hit_kind), 0);
    chk("R1 zone", int'(zone_code), 0);
    chk("R1 event", int'(event_pulse), 0);
    chk("R1 raw", int'(irq_raw), 0);

    // R2/R3 sweep: channel 0 rising edge, all edge and control modes, both levels
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        for (int lv = 0; lv < 2; lv++) begin
          rise_mode = {2'd0, 2'(m)}; fall_mode = '0;
          level_in[0] = lv[0];
          if (lv == 1) begin hi_mode = {2'd0, 2'(c)}; lo_mode = {2'd0, (c == 0) ? 2'd1 : 2'd0}; end
          else begin lo_mode = {2'd0, 2'(c)}; hi_mode = {2'd0, (c == 0) ? 2'd1 : 2'd0}; end
          do_clr();
          wait_n(4);
          pulse_in[0] = 1'b1;
          wait_n(8);
          chk($sformatf("R2 R3 ch0 rise m=%0d c=%0d lv=%0d", m, c, lv),
              int'($signed(count)), exp_step(m, c));
          pulse_in[0] = 1'b0;
          wait_n(8);
        end

    // R2/R3 sweep: channel 1 falling edge
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        for (int lv = 0; lv < 2; lv++) begin
          rise_mode = '0; fall_mode = {2'(m), 2'd0};
          level_in[1] = lv[0];
          if (lv == 1) begin hi_mode = {2'(c), 2'd0}; lo_mode = {(c == 0) ? 2'd1 : 2'd0, 2'd0}; end
          else begin lo_mode = {2'(c), 2'd0}; hi_mode = {(c == 0) ? 2'd1 : 2'd0, 2'd0}; end
          pulse_in[1] = 1'b1;
          wait_n(8);
          do_clr();
          wait_n(2);
          pulse_in[1] = 1'b0;
          wait_n(8);
          chk($sformatf("R2 R3 ch1 fall m=%0d c=%0d lv=%0d", m, c, lv),
              int'($signed(count)), exp_step(m, c));
        end

    // R4 simultaneous steps
    level_in = '0; hi_mode = '0; lo_mode = '0; fall_mode = '0;
    rise_mode = 4'b0101;
    do_clr();
    pulse_in = 2'b11;
    wait_n(8);
    chk("R4 both up", int'($signed(count)), 2);
    pulse_in = 2'b00;
    wait_n(8);
    rise_mode = 4'b1001;
    pulse_in = 2'b11;
    wait_n(8);
    chk("R4 up plus down", int'($signed(count)), 2);
    pulse_in = 2'b00;
    wait_n(8);
    rise_mode = 4'b1010;
    pulse_in = 2'b11;
    wait_n(8);
    chk("R4 both down", int'($signed(count)), 0);
    pulse_in = 2'b00;
    wait_n(8);

    // R5 filter
    rise_mode = 4'b0001;
    filt_en = 1'b1; filt_thresh = 10'd5;
    do_clr();
    pulse_in[0] = 1'b1; wait_n(3); pulse_in[0] = 1'b0; wait_n(12);
    chk("R5 narrow pulse dropped", int'($signed(count)), 0);
    pulse_in[0] = 1'b1; wait_n(4); pulse_in[0] = 1'b0; wait_n(12);
    chk("R5 width T-1 dropped", int'($signed(count)), 0);
    pulse_in[0] = 1'b1; wait_n(5); pulse_in[0] = 1'b0; wait_n(12);
    chk("R5 width T accepted", int'($signed(count)), 1);
    pulse_in[0] = 1'b1; wait_n(12); pulse_in[0] = 1'b0; wait_n(12);
    chk("R5 wide pulse accepted", int'($signed(count)), 2);
    filt_en = 1'b0; filt_thresh = '0;

    // R6 hold and clear
    hold_cnt = 1'b1;
    bump0();
    chk("R6 hold freezes", int'($signed(count)), 2);
    do_clr();
    chk("R6 clear during hold", int'($signed(count)), 0);
    hold_cnt = 1'b0;
    bump0();
    chk("R6 counts after release", int'($signed(count)), 1);

    // R7 disabled targets never hit
    do_clr();
    cmp_en = 5'b00000; thresh0 = 16'd2;
    bump0(); bump0();
    chk("R7 disabled no raw", int'(irq_raw), 0);
    chk("R7 disabled no record", int'(hit_kind), 0);

    // R7/R9/R10/R11 threshold 0 equality, positive zone
    do_clr();
    cmp_en = 5'b01000; thresh0 = 16'd3; irq_en = 1'b1;
    bump0(); bump0();
    chk("R7 below thresh0 no raw", int'(irq_raw), 0);
    bump0();
    chk("R7 thresh0 count", int'($signed(count)), 3);
    chk("R9 thresh0 record", int'(hit_kind), 8);
    chk("R10 positive zone", int'(zone_code), 3);
    chk("R11 raw set", int'(irq_raw), 1);
    chk("R11 status enabled", int'(irq_status), 1);
    irq_en = 1'b0;
    wait_n(1);
    chk("R11 status masked", int'(irq_status), 0);
    bump0();
    chk("R9 record kept without event", int'(hit_kind), 8);
    do_irq_clr();
    chk("R11 raw cleared", int'(irq_raw), 0);

    // R8 high limit wrap
    do_clr();
    cmp_en = 5'b00010; hi_lim = 16'd2;
    bump0(); bump0();
    chk("R8 hi wrap count", int'($signed(count)), 0);
    chk("R9 hi record", int'(hit_kind), 2);
    chk("R10 pos to zero", int'(zone_code), 0);
    do_irq_clr();

    // R8 low limit wrap (counting down)
    rise_mode = 4'b0010;
    do_clr();
    cmp_en = 5'b00100; lo_lim = 16'hfffe;
    bump0(); bump0();
    chk("R8 lo wrap count", int'($signed(count)), 0);
    chk("R9 lo record", int'(hit_kind), 4);
    chk("R10 neg to zero", int'(zone_code), 1);
    do_irq_clr();
    hi_lim = 16'h7fff; lo_lim = 16'h8000;

    // R10 negative zone via threshold 0 at -1
    do_clr();
    cmp_en = 5'b01000; thresh0 = 16'hffff;
    bump0();
    chk("R10 negative count", int'($signed(count)), -1);
    chk("R10 negative zone", int'(zone_code), 2);
    // R7 zero target from negative side
    rise_mode = 4'b0001; cmp_en = 5'b00001;
    bump0();
    chk("R7 zero hit count", int'($signed(count)), 0);
    chk("R9 zero record", int'(hit_kind), 1);
    chk("R10 neg to zero via zero", int'(zone_code), 1);
    // R7 threshold 1
    cmp_en = 5'b10000; thresh1 = 16'd1;
    bump0();
    chk("R9 thresh1 record", int'(hit_kind), 16);
    chk("R10 thresh1 zone", int'(zone_code), 3);
    // R10 zero reached from positive side
    rise_mode = 4'b0010; cmp_en = 5'b00001;
    bump0();
    chk("R10 pos to zero via zero", int'(zone_code), 0);
    do_irq_clr();

    // R8 limit reached by a double step overshooting
    rise_mode = 4'b0101;
    do_clr();
    cmp_en = 5'b00010; hi_lim = 16'd3;
    pulse_in = 2'b11; wait_n(8); pulse_in = 2'b00; wait_n(8);
    chk("R4 double step to 2", int'($signed(count)), 2);
    pulse_in = 2'b11; wait_n(8); pulse_in = 2'b00; wait_n(8);
    chk("R8 overshoot wraps", int'($signed(count)), 0);
    chk("R9 overshoot record", int'(hit_kind), 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule